// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block watches the recovered receive data of a T1/E1 line receiver, one bit period at a time, and raises a loss-of-signal flag once the line has delivered an unbroken run of zeros long enough to mean the far end is gone. A mark on either the positive or the negative rail counts as a one. The block lowers the flag only after the line has shown healthy ones density again. Healthy means a whole evaluation window of received bits that carries at least one mark in eight and has no zero run longer than a set limit.

The detector runs entirely in the recovered-clock domain. A per-bit enable marks the cycles that carry a received bit, and all other cycles are ignored. A hold input covers device reset and power-up: while it is asserted the flag is forced high. The flag can fall only through the exit rule once the hold is released. Exit windows are back to back and do not overlap. The first window starts with the first bit after the flag rose or after the hold was released.

Top module: `los_detector`

## Requirements
- R1: While `rst_n` is low or `hold_i` is high at a clock edge, `los_o` is 1 after that edge. When either is released, an exit window starts from the first enabled bit.
- R2: A bit counts as a one when `rx_pos` or `rx_neg` (or both) is 1 in an enabled cycle. A window whose marks arrive only on `rx_neg` is judged exactly as the same pattern on `rx_pos`.
- R3: While `los_o` is 0, `los_o` becomes 1 at the edge that samples the `ENTRY_ZEROS`-th consecutive zero (default 175, allowed range 160 to 190). After 174 consecutive zeros it is still 0.
- R4: While `los_o` is 0, a received one restarts the zero count at once. So 174 zeros, then one mark, then 174 zeros keeps `los_o` at 0.
- R5: While `los_o` is 1, `los_o` returns to 0 at the edge that samples the last bit of a `WIN_LEN`-bit window (default 175). This happens only if that window held at least ceil(`WIN_LEN`/8) ones (22 by default) and no run of more than `MAX_ZERO_RUN` zeros (default 100). Before that edge it stays 1.
- R6: A window with one one fewer than the minimum (21 by default) fails, and `los_o` stays 1.
- R7: A window with a run of `MAX_ZERO_RUN`+1 zeros fails even when its ones count is high. A run of exactly `MAX_ZERO_RUN` zeros does not fail it.
- R8: Windows do not overlap. After a failed window, the next `WIN_LEN` bits are judged afresh, with no count carried over.
- R9: Cycles with `bit_en` low change nothing: `los_o`, the zero count and the window position all keep their values, whatever the rails carry.
- R10: While `los_o` is 1 and `hold_i` is low, `los_o` changes only at the last bit of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Synchronous active-low reset; forces the flag high |
| hold_i | input | 1 | Reset/power-up hold; forces the flag high and restarts the exit window |
| bit_en | input | 1 | High in cycles that carry one received bit |
| rx_pos | input | 1 | Recovered positive-rail mark |
| rx_neg | input | 1 | Recovered negative-rail mark |
| los_o | output | 1 | Loss-of-signal flag, registered |

## Verification
The flag is one register deep. The bit sampled at a clock edge, or a hold or reset seen at that edge, shows on `los_o` just after that same edge, so each result is due zero cycles after its stimulus edge. The bench drives inputs on the falling edge and reads `los_o` 2 ns after the next rising edge, once per bit. Directed patterns check the flag on both sides of every threshold (bit 174 and bit 175, 21 and 22 ones, runs of 100 and 101 zeros). A random run compares `los_o` every cycle with a bit-level model held in bench tasks.

// File: rtl/los_det_pkg.sv
// Package: shared types and default limits for the loss-of-signal detector.
// Assumes one received bit per enabled clock cycle.
package los_det_pkg;

    // Flag state: LOCKED means data is present, LOST means loss of signal.
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_LOST   = 1'b1
    } los_state_e;

    localparam int DEF_ENTRY_ZEROS  = 175;
    localparam int DEF_WIN_LEN      = 175;
    localparam int DEF_DENS_DIV     = 8;
    localparam int DEF_MAX_ZERO_RUN = 100;

    // A bit is a one when either rail carries a mark.
    function automatic logic rail_mark(input logic pos, input logic neg);
        return pos | neg;
    endfunction

endpackage

// File: rtl/los_zero_run.sv
// Module: consecutive-zero counter for the detector's entry rule.
// Counts enabled zero bits and restarts on a one. It saturates at
// ENTRY_ZEROS instead of wrapping. hit_o pulses combinationally on the bit
// that completes the run. Assumes clear_i is held while the flag is set.
module los_zero_run #(
    parameter int ENTRY_ZEROS = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    input  logic mark_i,
    output logic hit_o
);
    localparam int CW = $clog2(ENTRY_ZEROS + 1);
    localparam logic [CW-1:0] LIMIT    = CW'(ENTRY_ZEROS);
    localparam logic [CW-1:0] LAST_ONE = CW'(ENTRY_ZEROS - 1);

    logic [CW-1:0] cnt_q;

    // Entry hit: this zero is the one that completes the run.
    assign hit_o = step_i & ~mark_i & ~clear_i & (cnt_q == LAST_ONE);

    // Zero-run counter with saturation and restart on a mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (mark_i) begin
                cnt_q <= '0;
            end else if (cnt_q < LIMIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/los_exit_window.sv
// Module: ones-density exit evaluator. It judges back-to-back WIN_LEN-bit
// windows. A window passes with at least ceil(WIN_LEN/DENS_DIV) ones and no
// zero run above MAX_ZERO_RUN. end_o and pass_o are combinational on the
// last bit. Assumes clear_i is held whenever the flag is not set.
module los_exit_window #(
    parameter int WIN_LEN      = 175,
    parameter int DENS_DIV     = 8,
    parameter int MAX_ZERO_RUN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    input  logic mark_i,
    output logic end_o,
    output logic pass_o
);
    localparam int MIN_ONES = (WIN_LEN + DENS_DIV - 1) / DENS_DIV;
    localparam int IW = $clog2(WIN_LEN);
    localparam int OW = $clog2(MIN_ONES + 1);
    localparam int RW = $clog2(MAX_ZERO_RUN + 2);
    localparam logic [IW-1:0] IDX_LAST = IW'(WIN_LEN - 1);
    localparam logic [OW-1:0] ONES_LIM = OW'(MIN_ONES);
    localparam logic [RW-1:0] RUN_LIM  = RW'(MAX_ZERO_RUN + 1);

    logic [IW-1:0] idx_q;
    logic [OW-1:0] ones_q, ones_nx;
    logic [RW-1:0] run_q, run_nx;
    logic          fail_q, fail_nx;
    logic          last_bit;

    // Next-state counts for this bit, including the bit itself.
    always_comb begin
        ones_nx = ones_q;
        if (mark_i && (ones_q < ONES_LIM)) begin
            ones_nx = ones_q + 1'b1;
        end
        if (mark_i) begin
            run_nx = '0;
        end else if (run_q < RUN_LIM) begin
            run_nx = run_q + 1'b1;
        end else begin
            run_nx = run_q;
        end
        fail_nx = fail_q | (run_nx == RUN_LIM);
    end

    // Window verdict on the final bit.
    assign last_bit = (idx_q == IDX_LAST);
    assign end_o    = step_i & ~clear_i & last_bit;
    assign pass_o   = end_o & (ones_nx == ONES_LIM) & ~fail_nx;

    // Window position and statistics; restart on clear or at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ones_q <= '0;
            run_q  <= '0;
            fail_q <= 1'b0;
        end else if (clear_i || (step_i && last_bit)) begin
            idx_q  <= '0;
            ones_q <= '0;
            run_q  <= '0;
            fail_q <= 1'b0;
        end else if (step_i) begin
            idx_q  <= idx_q + 1'b1;
            ones_q <= ones_nx;
            run_q  <= run_nx;
            fail_q <= fail_nx;
        end
    end
endmodule

// File: rtl/los_detector.sv
// Module: receive loss-of-signal detector top. It combines the entry
// zero-run counter and the exit density window around a single flag
// register. Assumes one bit per bit_en cycle. The hold input stands for
// device reset or power-up and forces the flag high.
module los_detector #(
    parameter int ENTRY_ZEROS  = los_det_pkg::DEF_ENTRY_ZEROS,
    parameter int WIN_LEN      = los_det_pkg::DEF_WIN_LEN,
    parameter int DENS_DIV     = los_det_pkg::DEF_DENS_DIV,
    parameter int MAX_ZERO_RUN = los_det_pkg::DEF_MAX_ZERO_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic bit_en,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic los_o
);
    import los_det_pkg::*;

    los_state_e state_q;
    logic mark, zr_clear, win_clear, zr_hit, win_end, win_pass;

    // Rail merge and counter clears derived from the current state.
    assign mark      = rail_mark(rx_pos, rx_neg);
    assign zr_clear  = hold_i | (state_q == ST_LOST);
    assign win_clear = hold_i | (state_q == ST_LOCKED);

    los_zero_run #(
        .ENTRY_ZEROS (ENTRY_ZEROS)
    ) u_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (zr_clear),
        .step_i  (bit_en),
        .mark_i  (mark),
        .hit_o   (zr_hit)
    );

    los_exit_window #(
        .WIN_LEN      (WIN_LEN),
        .DENS_DIV     (DENS_DIV),
        .MAX_ZERO_RUN (MAX_ZERO_RUN)
    ) u_exit_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (win_clear),
        .step_i  (bit_en),
        .mark_i  (mark),
        .end_o   (win_end),
        .pass_o  (win_pass)
    );

    // Flag register: forced on reset/hold, set on entry hit, cleared on pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOST;
        end else if (hold_i) begin
            state_q <= ST_LOST;
        end else begin
            case (state_q)
                ST_LOCKED: if (zr_hit)   state_q <= ST_LOST;
                ST_LOST:   if (win_pass) state_q <= ST_LOCKED;
                default:                 state_q <= ST_LOST;
            endcase
        end
    end

    assign los_o = (state_q == ST_LOST);
endmodule

// File: rtl/los_detector_chk.sv
// Module: assertion checker for los_detector, attached by bind below.
// Observes the top's ports and the verdicts of its two sub-blocks.
module los_detector_chk #(
    parameter int ENTRY_ZEROS = 175
) (
    input logic clk,
    input logic rst_n,
    input logic hold_i,
    input logic bit_en,
    input logic rx_pos,
    input logic rx_neg,
    input logic los_o,
    input logic zr_hit,
    input logic win_end,
    input logic win_pass
);
    // R3: entry threshold parameter within its allowed band.
    initial begin
        a_r3_entry_range: assert (ENTRY_ZEROS >= 160 && ENTRY_ZEROS <= 190)
            else $error("ENTRY_ZEROS out of range");
    end

    // R1: reset forces the flag.
    a_r1_reset_sets: assert property (@(posedge clk) disable iff (hold_i)
        !rst_n |=> los_o);

    // R1: hold forces the flag.
    a_r1_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> los_o);

    // R3: the flag rises only on an enabled zero bit or on hold.
    a_r3_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_o) |-> ($past(hold_i) ||
                          ($past(bit_en) && !$past(rx_pos) && !$past(rx_neg))));

    // R3: entry hit only while the flag is low.
    a_r3_hit_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        zr_hit |-> !los_o);

    // R4: a received one while low keeps the flag low.
    a_r4_mark_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_o && bit_en && !hold_i && (rx_pos || rx_neg)) |=> !los_o);

    // R5: the flag falls only after a passing window verdict.
    a_r5_fall_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_o) |-> $past(win_pass));

    // R10: window verdicts occur only while the flag is high.
    a_r10_window_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> los_o);

    // R9: an idle cycle leaves the flag unchanged.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !hold_i) |=> $stable(los_o));
endmodule

bind los_detector los_detector_chk #(
    .ENTRY_ZEROS (ENTRY_ZEROS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold_i),
    .bit_en   (bit_en),
    .rx_pos   (rx_pos),
    .rx_neg   (rx_neg),
    .los_o    (los_o),
    .zr_hit   (zr_hit),
    .win_end  (win_end),
    .win_pass (win_pass)
);

// File: tb/los_detector_tb_top.sv
// Bench: directed threshold cases followed by seeded random stimulus,
// checked against a bit-level model kept in bench tasks.
module los_detector_tb_top;
    localparam int ENTRY = 175;
    localparam int WIN   = 175;
    localparam int DIV   = 8;
    localparam int MAXZ  = 100;
    localparam int MINO  = (WIN + DIV - 1) / DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_i = 1'b0;
    logic bit_en = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic los_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Model state (post-reset values).
    bit m_los  = 1'b1;
    int m_run  = 0;
    int m_idx  = 0;
    int m_ones = 0;
    int m_zrun = 0;
    bit m_fail = 1'b0;

    always #5 clk = ~clk;

    los_detector dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_i),
        .bit_en (bit_en),
        .rx_pos (rx_pos),
        .rx_neg (rx_neg),
        .los_o  (los_o)
    );

    task automatic win_restart();
        m_idx = 0; m_ones = 0; m_zrun = 0; m_fail = 1'b0;
    endtask

    // Expected flag after one cycle, from the requirements.
    task automatic model_step(input bit h, input bit en, input bit mk);
        if (h) begin
            m_los = 1'b1; m_run = 0; win_restart();
        end else if (en) begin
            if (!m_los) begin
                if (mk) m_run = 0;
                else if (m_run < ENTRY) m_run++;
                if (m_run == ENTRY) begin
                    m_los = 1'b1; m_run = 0; win_restart();
                end
            end else begin
                m_idx++;
                if (mk) begin m_ones++; m_zrun = 0; end
                else m_zrun++;
                if (m_zrun > MAXZ) m_fail = 1'b1;
                if (m_idx == WIN) begin
                    if (m_ones >= MINO && !m_fail) begin
                        m_los = 1'b0; m_run = 0;
                    end
                    win_restart();
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic exp);
        total++;
        if (los_o !== exp) begin
            bad++;
            $display("FAIL %s: los_o=%b expected=%b at %0t", req, los_o, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, sample 2 ns after the rising edge.
    task automatic cycle(input bit h, input bit en, input bit p, input bit n);
        @(negedge clk);
        hold_i = h; bit_en = en; rx_pos = p; rx_neg = n;
        @(posedge clk);
        #2;
        model_step(h, en, p | n);
    endtask

    task automatic run_bits(input int cnt, input bit p, input bit n);
        for (int i = 0; i < cnt; i++) cycle(1'b0, 1'b1, p, n);
    endtask

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 after reset", 1'b1);

        // R5 / R10: all-ones window clears on bit 175, not before.
        run_bits(WIN - 1, 1'b1, 1'b0);
        chk("R10 before window end", 1'b1);
        run_bits(1, 1'b1, 1'b0);
        chk("R5 window pass", 1'b0);

        // R3 / R4: entry threshold and restart on a one.
        run_bits(ENTRY - 1, 1'b0, 1'b0);
        chk("R3 174 zeros", 1'b0);
        run_bits(1, 1'b1, 1'b0);
        run_bits(ENTRY - 1, 1'b0, 1'b0);
        chk("R4 run restarted", 1'b0);
        run_bits(1, 1'b0, 1'b0);
        chk("R3 175th zero", 1'b1);

        // R2 / R5: 22 marks on the negative rail only.
        for (int i = 0; i < WIN; i++) cycle(1'b0, 1'b1, 1'b0, (i % 8) == 0);
        chk("R2 R5 minimum ones on neg rail", 1'b0);

        // R6 / R8: 21 marks fail, next all-ones window passes.
        run_bits(ENTRY, 1'b0, 1'b0);
        chk("R3 re-entry", 1'b1);
        for (int i = 0; i < WIN; i++) cycle(1'b0, 1'b1, (i % 8) == 0 && i < 161, 1'b0);
        chk("R6 21 ones fails", 1'b1);
        run_bits(WIN - 1, 1'b0, 1'b1);
        chk("R8 fresh window pending", 1'b1);
        run_bits(1, 1'b0, 1'b1);
        chk("R8 fresh window passes", 1'b0);

        // R7: run of 101 zeros fails, run of 100 passes.
        run_bits(ENTRY, 1'b0, 1'b0);
        for (int i = 0; i < WIN; i++) cycle(1'b0, 1'b1, i < 74, 1'b0);
        chk("R7 101 zero run fails", 1'b1);
        for (int i = 0; i < WIN; i++) cycle(1'b0, 1'b1, i < 74 || i == WIN - 1, 1'b0);
        chk("R7 100 zero run passes", 1'b0);

        // R9: idle cycles do not advance the window or the zero run.
        run_bits(ENTRY, 1'b0, 1'b0);
        run_bits(100, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 idle while lost", 1'b1);
        run_bits(WIN - 101, 1'b1, 1'b0);
        chk("R9 window not advanced", 1'b1);
        run_bits(1, 1'b1, 1'b0);
        chk("R9 window completes", 1'b0);
        run_bits(ENTRY - 1, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 idle zeros ignored", 1'b0);
        run_bits(1, 1'b0, 1'b0);
        chk("R9 R3 run kept across idle", 1'b1);
        run_bits(WIN, 1'b1, 1'b0);

        // R1: hold forces the flag and restarts the window.
        cycle(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R1 hold", 1'b1);
        run_bits(WIN - 1, 1'b1, 1'b0);
        chk("R1 window after hold pending", 1'b1);
        run_bits(1, 1'b1, 1'b0);
        chk("R1 window after hold passes", 1'b0);

        // Random segments of varying density against the model.
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            int dens;
            len  = 100 + int'($urandom_range(0, 400));
            dens = int'($urandom_range(0, 5));
            for (int i = 0; i < len; i++) begin
                bit en, h, mk;
                int rail;
                en = ($urandom_range(0, 7) != 0);
                h  = ($urandom_range(0, 2999) == 0);
                case (dens)
                    0:       mk = 1'b0;
                    1:       mk = ($urandom_range(0, 15) == 0);
                    2:       mk = ($urandom_range(0, 7) == 0);
                    3:       mk = ($urandom_range(0, 3) == 0);
                    4:       mk = ($urandom_range(0, 1) == 0);
                    default: mk = ($urandom_range(0, 9) != 0);
                endcase
                rail = int'($urandom_range(0, 2));
                cycle(h, en, mk && rail != 1, mk && rail != 0);
                chk("R2 R3 R5 R6 R7 random", m_los);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule